// File: doc/BRIEF.md
# Encoder Event and Counter Capture Unit

This block sits beside a quadrature-encoder counter core. It gathers four motion events (motion-watchdog timeout, home, position-compare match and Z index) into sticky status bits. Software clears those bits by writing a mask. Four independent enable masks, all using the status bit layout, route the status to an interrupt line and a DMA request. They also route fresh events to a trigger pulse and to an automatic load of the read bank.

The counter core supplies four counter values: Z, phase, speed and timer. The unit copies all four together into a read bank when software issues a read command or when an event enabled for read capture fires. This gives a coherent picture of all four counters taken on a single clock edge. Two snapshot banks capture the same four values on external snapshot strobes, but only while snapshot capture is enabled.

A motion watchdog counts cycles in which the phase counter does not change. When that count reaches a programmed timeout, it raises the watchdog event.

Top module: `enc_event_unit`

## Requirements
- R1: After reset the status, interrupt, DMA request, trigger output and all three banks are zero.
- R2: An event pulse sets its status bit one clock later, and the bit stays set until it is cleared. Status bit positions are [3] watchdog, [2] home, [1] position compare, [0] Z index.
- R3: A write with `clr_we_i` high clears every status bit whose `clr_mask_i` bit is 1 and leaves the other bits unchanged (write-1-to-clear).
- R4: When an event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R5: `irq_o` is high exactly when some status bit is set with its `irq_en_i` bit set. `dma_req_o` follows the same rule with `dma_en_i`.
- R6: `trg_o` is a single-cycle pulse one clock after any event whose `trg_en_i` bit is set. Events with the enable bit clear produce no pulse.
- R7: A `sw_read_i` pulse copies all four counters into `rd_bank_o` on one edge. The bank holds Z in bits [127:96], phase in [95:64], speed in [63:32] and timer in [31:0] (at a width of 32). Without a load the bank holds its value.
- R8: An event whose `rd_en_i` bit is set loads the read bank the same way as R7. An event whose bit is clear leaves the bank unchanged.
- R9: `snap0_i` and `snap1_i` load their snapshot bank only while `snap_en_i` is high. Otherwise they are ignored.
- R10: With the watchdog enabled and a nonzero timeout T, after T clock edges with no change of `ph_cnt_i`, the watchdog status bit is set on the T-th edge and not before. A disabled watchdog never sets the bit, and neither does a timeout of zero.
- R11: The watchdog fires once per quiet interval. After its bit is cleared, it stays clear until the phase counter changes and a further T quiet edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zidx_i | input | 1 | Z index event pulse |
| cmp_match_i | input | 1 | Position-compare match pulse |
| home_i | input | 1 | Home event pulse |
| z_cnt_i | input | CNT_W | Current Z counter |
| ph_cnt_i | input | CNT_W | Current phase counter |
| spd_cnt_i | input | CNT_W | Current speed counter |
| tmr_cnt_i | input | CNT_W | Current timer counter |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_mask_i | input | 4 | Status bits to clear |
| irq_en_i | input | 4 | Interrupt enable mask |
| dma_en_i | input | 4 | DMA request enable mask |
| trg_en_i | input | 4 | Trigger output enable mask |
| rd_en_i | input | 4 | Read-bank load enable mask |
| sw_read_i | input | 1 | Software read command |
| snap_en_i | input | 1 | Snapshot capture enable |
| snap0_i | input | 1 | Snapshot 0 strobe |
| snap1_i | input | 1 | Snapshot 1 strobe |
| wdg_en_i | input | 1 | Motion watchdog enable |
| wdg_timeout_i | input | WDG_W | Watchdog timeout in cycles |
| status_o | output | 4 | Sticky event status |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |
| trg_o | output | 1 | Trigger pulse |
| rd_bank_o | output | 4*CNT_W | Read bank |
| snap0_bank_o | output | 4*CNT_W | Snapshot 0 bank |
| snap1_bank_o | output | 4*CNT_W | Snapshot 1 bank |

## Verification
The sharpest corner case is an event and a clear landing on the same bit in the same cycle. A design that lets the clear win would drop that event silently. Other patterns check that a clear mask touches only its own bits, and that the trigger pulse ends after one cycle even when the status bit stays set.

The watchdog is probed one edge before and one edge at its timeout, which exposes an off-by-one count. It is also checked that a cleared watchdog bit stays clear until motion resumes. A watchdog that kept counting past the timeout would fire again and again.

Masked events and snapshot strobes with capture disabled must leave the banks untouched. A design with a missing gate would overwrite captured data.

// File: rtl/enc_event_pkg.sv
package enc_event_pkg;
  localparam int NUM_EV   = 4;
  localparam int EV_Z     = 0;
  localparam int EV_CMP   = 1;
  localparam int EV_HOME  = 2;
  localparam int EV_WDG   = 3;
  localparam int NUM_CNT  = 4;
  localparam int NUM_BANK = 3;
  localparam int BANK_RD  = 0;
  localparam int BANK_S0  = 1;
  localparam int BANK_S1  = 2;

  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/enc_evt_status.sv
module enc_evt_status
  import enc_event_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ev_vec_t ev_i,
  input  logic    clr_we_i,
  input  ev_vec_t clr_mask_i,
  input  ev_vec_t irq_en_i,
  input  ev_vec_t dma_en_i,
  input  ev_vec_t trg_en_i,
  input  ev_vec_t rd_en_i,
  output ev_vec_t status_o,
  output logic    irq_o,
  output logic    dma_o,
  output logic    trg_o,
  output logic    rd_load_o
);
  ev_vec_t status_q;
  ev_vec_t clr_eff;
  logic    trg_q;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      trg_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_eff) | ev_i;
      trg_q    <= |(ev_i & trg_en_i);
    end
  end

  assign status_o  = status_q;
  assign irq_o     = |(status_q & irq_en_i);
  assign dma_o     = |(status_q & dma_en_i);
  assign trg_o     = trg_q;
  assign rd_load_o = |(ev_i & rd_en_i);
endmodule

// File: rtl/enc_motion_wdog.sv
module enc_motion_wdog #(
  parameter int CNT_W = 32,
  parameter int WDG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ph_cnt_i,
  input  logic             en_i,
  input  logic [WDG_W-1:0] timeout_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] ph_prev_q;
  logic [WDG_W-1:0] cnt_q;
  logic [WDG_W:0]   cnt_inc;
  logic             active;

  assign active  = (ph_cnt_i != ph_prev_q);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign fire_o  = en_i && !active && (timeout_i != '0) &&
                   (cnt_inc == {1'b0, timeout_i});

  // counter saturates at timeout so the event fires once per quiet interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_prev_q <= '0;
      cnt_q     <= '0;
    end else begin
      ph_prev_q <= ph_cnt_i;
      if (!en_i || active)         cnt_q <= '0;
      else if (cnt_q != timeout_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/enc_cnt_bank.sv
module enc_cnt_bank #(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 4,
  localparam int BW     = CNT_W * NUM_CNT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] cnt_i,
  output logic [BW-1:0] bank_o
);
  logic [BW-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_q <= '0;
    else if (load_i) bank_q <= cnt_i;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/enc_event_unit.sv
module enc_event_unit
  import enc_event_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int WDG_W = 16,
  localparam int BW   = CNT_W * NUM_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zidx_i,
  input  logic             cmp_match_i,
  input  logic             home_i,
  input  logic [CNT_W-1:0] z_cnt_i,
  input  logic [CNT_W-1:0] ph_cnt_i,
  input  logic [CNT_W-1:0] spd_cnt_i,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  input  logic             clr_we_i,
  input  logic [3:0]       clr_mask_i,
  input  logic [3:0]       irq_en_i,
  input  logic [3:0]       dma_en_i,
  input  logic [3:0]       trg_en_i,
  input  logic [3:0]       rd_en_i,
  input  logic             sw_read_i,
  input  logic             snap_en_i,
  input  logic             snap0_i,
  input  logic             snap1_i,
  input  logic             wdg_en_i,
  input  logic [WDG_W-1:0] wdg_timeout_i,
  output logic [3:0]       status_o,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic             trg_o,
  output logic [BW-1:0]    rd_bank_o,
  output logic [BW-1:0]    snap0_bank_o,
  output logic [BW-1:0]    snap1_bank_o
);
  ev_vec_t              ev;
  logic                 wdg_fire;
  logic                 rd_load;
  logic [BW-1:0]        cnt_cat;
  logic [NUM_BANK-1:0]  bank_load;
  logic [BW-1:0]        bank_q [NUM_BANK];

  always_comb begin
    ev          = '0;
    ev[EV_Z]    = zidx_i;
    ev[EV_CMP]  = cmp_match_i;
    ev[EV_HOME] = home_i;
    ev[EV_WDG]  = wdg_fire;
  end

  assign cnt_cat = {z_cnt_i, ph_cnt_i, spd_cnt_i, tmr_cnt_i};

  enc_motion_wdog #(.CNT_W(CNT_W), .WDG_W(WDG_W)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_cnt_i  (ph_cnt_i),
    .en_i      (wdg_en_i),
    .timeout_i (wdg_timeout_i),
    .fire_o    (wdg_fire)
  );

  enc_evt_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .irq_en_i   (irq_en_i),
    .dma_en_i   (dma_en_i),
    .trg_en_i   (trg_en_i),
    .rd_en_i    (rd_en_i),
    .status_o   (status_o),
    .irq_o      (irq_o),
    .dma_o      (dma_req_o),
    .trg_o      (trg_o),
    .rd_load_o  (rd_load)
  );

  always_comb begin
    bank_load          = '0;
    bank_load[BANK_RD] = sw_read_i | rd_load;
    bank_load[BANK_S0] = snap_en_i & snap0_i;
    bank_load[BANK_S1] = snap_en_i & snap1_i;
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    enc_cnt_bank #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (bank_load[b]),
      .cnt_i  (cnt_cat),
      .bank_o (bank_q[b])
    );
  end

  assign rd_bank_o    = bank_q[BANK_RD];
  assign snap0_bank_o = bank_q[BANK_S0];
  assign snap1_bank_o = bank_q[BANK_S1];
endmodule

// File: rtl/enc_event_unit_chk.sv
module enc_event_unit_chk #(
  parameter int CNT_W = 32,
  localparam int BW   = CNT_W * 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             zidx_i,
  input logic             cmp_match_i,
  input logic             home_i,
  input logic [CNT_W-1:0] z_cnt_i,
  input logic [CNT_W-1:0] ph_cnt_i,
  input logic [CNT_W-1:0] spd_cnt_i,
  input logic [CNT_W-1:0] tmr_cnt_i,
  input logic             clr_we_i,
  input logic [3:0]       clr_mask_i,
  input logic [3:0]       irq_en_i,
  input logic [3:0]       trg_en_i,
  input logic             sw_read_i,
  input logic             snap_en_i,
  input logic             wdg_en_i,
  input logic             wdg_fire,
  input logic [3:0]       status_o,
  input logic             irq_o,
  input logic             trg_o,
  input logic [BW-1:0]    rd_bank_o,
  input logic [BW-1:0]    snap0_bank_o
);
  logic [3:0]    clr_eff;
  logic [3:0]    keep;
  logic [3:0]    evs;
  logic [BW-1:0] cnt_cat;

  assign clr_eff = clr_we_i ? clr_mask_i : 4'b0;
  assign keep    = status_o & ~clr_eff;
  assign evs     = {wdg_fire, home_i, cmp_match_i, zidx_i};
  assign cnt_cat = {z_cnt_i, ph_cnt_i, spd_cnt_i, tmr_cnt_i};

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(keep)) == $past(keep))); // R2
  AST_CLEAR_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_mask_i[0] && !zidx_i) |=> !status_o[0]); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (home_i && clr_we_i && clr_mask_i[2]) |=> status_o[2]); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((status_o & irq_en_i) != 4'b0)); // R5
  AST_TRG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_o |-> $past((evs & trg_en_i) != 4'b0)); // R6
  AST_READ_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_read_i |=> (rd_bank_o == $past(cnt_cat))); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_en_i |=> $stable(snap0_bank_o)); // R9
  AST_WDG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdg_en_i |=> !$rose(status_o[3])); // R10
endmodule

bind enc_event_unit enc_event_unit_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/enc_event_unit_bench.sv
module enc_event_unit_bench;
  localparam int CW = 32;
  localparam int WW = 16;
  localparam int BW = 4 * CW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          zidx_i = 0, cmp_match_i = 0, home_i = 0;
  logic [CW-1:0] z_cnt_i = 0, ph_cnt_i = 0, spd_cnt_i = 0, tmr_cnt_i = 0;
  logic          clr_we_i = 0;
  logic [3:0]    clr_mask_i = 0, irq_en_i = 0, dma_en_i = 0, trg_en_i = 0, rd_en_i = 0;
  logic          sw_read_i = 0, snap_en_i = 0, snap0_i = 0, snap1_i = 0, wdg_en_i = 0;
  logic [WW-1:0] wdg_timeout_i = 0;
  logic [3:0]    status_o;
  logic          irq_o, dma_req_o, trg_o;
  logic [BW-1:0] rd_bank_o, snap0_bank_o, snap1_bank_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  enc_event_unit #(.CNT_W(CW), .WDG_W(WW)) u_enc_event_unit (.*);

  // {home, cmp, z, clr_we, clr_mask[3:0], expected status[3:0]}
  localparam logic [11:0] VEC [10] = '{
    12'b001_0_0000_0001,
    12'b010_0_0000_0011,
    12'b000_1_0001_0010,
    12'b100_1_0100_0110,
    12'b000_0_0000_0110,
    12'b000_1_1111_0000,
    12'b111_0_0000_0111,
    12'b001_1_0011_0101,
    12'b000_1_0100_0001,
    12'b000_1_0000_0001
  };

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_cnt(input logic [CW-1:0] z, ph, sp, tm);
    z_cnt_i = z; ph_cnt_i = ph; spd_cnt_i = sp; tmr_cnt_i = tm;
  endtask

  task automatic clear_all();
    clr_we_i = 1; clr_mask_i = 4'hF;
    cyc(1);
    clr_we_i = 0; clr_mask_i = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] snapv;
    cyc(2);
    rst_ni = 1;
    cyc(1);
    // R1 reset state
    check("R1 status", BW'(status_o), 0);
    check("R1 irq/dma/trg", BW'({irq_o, dma_req_o, trg_o}), 0);
    check("R1 banks", rd_bank_o | snap0_bank_o | snap1_bank_o, 0);

    irq_en_i = 4'b0101; dma_en_i = 4'b1000; trg_en_i = 4'b0001;
    foreach (VEC[i]) begin
      {home_i, cmp_match_i, zidx_i} = VEC[i][11:9];
      clr_we_i = VEC[i][8]; clr_mask_i = VEC[i][7:4];
      cyc(1);
      check($sformatf("R2 R3 R4 status vec%0d", i), BW'(status_o), BW'(VEC[i][3:0]));
      check($sformatf("R5 irq vec%0d", i), BW'(irq_o), BW'(|(VEC[i][3:0] & irq_en_i)));
      check($sformatf("R5 dma vec%0d", i), BW'(dma_req_o), BW'(|(VEC[i][3:0] & dma_en_i)));
      check($sformatf("R6 trg vec%0d", i), BW'(trg_o), BW'(VEC[i][9]));
    end
    {home_i, cmp_match_i, zidx_i} = 0; clr_we_i = 0; clr_mask_i = 0;
    cyc(1);
    check("R6 trg single cycle", BW'(trg_o), 0);

    // R7 software read
    set_cnt(32'h11, 32'h22, 32'h33, 32'h44);
    sw_read_i = 1; cyc(1); sw_read_i = 0;
    check("R7 read bank", rd_bank_o, {32'h11, 32'h22, 32'h33, 32'h44});
    set_cnt(32'h55, 32'h66, 32'h77, 32'h88);
    cyc(2);
    check("R7 read bank hold", rd_bank_o, {32'h11, 32'h22, 32'h33, 32'h44});

    // R8 event-driven load
    rd_en_i = 4'b0010;
    home_i = 1; cyc(1); home_i = 0;
    check("R8 masked event no load", rd_bank_o, {32'h11, 32'h22, 32'h33, 32'h44});
    cmp_match_i = 1; cyc(1); cmp_match_i = 0;
    check("R8 enabled event load", rd_bank_o, {32'h55, 32'h66, 32'h77, 32'h88});
    rd_en_i = 0;

    // R9 snapshots
    set_cnt(32'hA1, 32'hA2, 32'hA3, 32'hA4);
    snap0_i = 1; cyc(1); snap0_i = 0;
    check("R9 snap0 ignored when disabled", snap0_bank_o, 0);
    snap_en_i = 1; snap1_i = 1; cyc(1); snap1_i = 0;
    check("R9 snap1 load", snap1_bank_o, {32'hA1, 32'hA2, 32'hA3, 32'hA4});
    check("R9 snap0 untouched", snap0_bank_o, 0);
    set_cnt(32'hB1, 32'hB2, 32'hB3, 32'hB4);
    snap0_i = 1; cyc(1); snap0_i = 0;
    snapv = {32'hB1, 32'hB2, 32'hB3, 32'hB4};
    check("R9 snap0 load", snap0_bank_o, snapv);
    snap_en_i = 0;

    // R10 watchdog timing
    set_cnt(0, 32'd100, 0, 0);
    clear_all();
    cyc(2);
    wdg_timeout_i = 5; wdg_en_i = 1;
    cyc(4);
    check("R10 wdg not before timeout", BW'(status_o[3]), 0);
    cyc(1);
    check("R10 wdg at timeout", BW'(status_o[3]), 1);
    check("R5 dma from wdg", BW'(dma_req_o), 1);

    // R11 one fire per quiet interval
    clear_all();
    cyc(10);
    check("R11 no refire while quiet", BW'(status_o[3]), 0);
    ph_cnt_i = 32'd101;
    cyc(5);
    check("R11 not before new timeout", BW'(status_o[3]), 0);
    cyc(1);
    check("R11 refire after motion", BW'(status_o[3]), 1);

    // R10 disabled and zero timeout
    wdg_en_i = 0; clear_all();
    cyc(20);
    check("R10 disabled never fires", BW'(status_o[3]), 0);
    wdg_en_i = 1; wdg_timeout_i = 0;
    cyc(20);
    check("R10 zero timeout never fires", BW'(status_o[3]), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule